// File: doc/BRIEF.md
# Burst Header Receiver and Destination Router

This block sits at the entry of a burst switch's control path. Each cycle it can take one fixed-format 34-bit burst header from an upstream deframer. It checks the header's sync byte and its parity byte. A header that passes both checks is turned into a 24-bit scheduling request: the destination field is removed, and the current slot count is appended as an arrival timestamp. The request is then presented on the one of four request ports that the destination field selects. A header that fails either check produces no request and increments a saturating error counter.

A single holding register sits between the input and the four ports. While the request it holds waits on a port that is not ready, the input ready signal is low, so no valid header is ever lost. When the selected port is ready, the held request leaves and a new header can be accepted on the same clock edge, which sustains one header per cycle. The per-destination queues and the channel scheduler that follow the block are separate units.

Top module: `burst_hdr_rx`

## Requirements
- R1: The header layout is qos[33], dest[32:31], group[30:29], channel[28:25], length[24:21], offset[20:16], parity[15:8], sync[7:0]. An accepted header whose sync byte is not 8'hA5 produces no request and increments `frame_err_cnt` by one.
- R2: Let P be the 18-bit payload hdr_data[33:16], zero-extended to 24 bits. The parity byte must equal P[23:16] ^ P[15:8] ^ P[7:0]. An accepted header with a correct sync byte and a wrong parity byte produces no request and increments `parity_err_cnt` by one.
- R3: When a header fails both checks, only `frame_err_cnt` counts it.
- R4: A valid header accepted at a clock edge raises exactly bit `dest` of `req_valid` from that edge on. No other port sees a request from it.
- R5: A request is 24 bits wide, laid out as {qos, group, channel, length, offset, timestamp}, with the timestamp in the low 8 bits. Port d carries it on `req_data[d*24 +: 24]`.
- R6: The timestamp equals the value of `slot_cnt` at the clock edge that accepts the header.
- R7: At most one bit of `req_valid` is high at any time.
- R8: While a pending request's port is not ready, `hdr_ready` stays low and the request stays unchanged. The ready inputs of the other ports have no effect.
- R9: When the pending request's port is ready, the request leaves and a new header is accepted on the same edge, giving one header per cycle.
- R10: Both error counters stop at 16'hFFFF and do not wrap.
- R11: After reset, `req_valid` is zero, both counters are zero and `hdr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_valid | input | 1 | Header word is present |
| hdr_ready | output | 1 | Block can take a header this cycle |
| hdr_data | input | 34 | Burst header word |
| slot_cnt | input | 8 | Current slot count, used as the timestamp |
| req_valid | output | 4 | One valid bit per destination port |
| req_ready | input | 4 | One ready bit per destination port |
| req_data | output | 96 | Four 24-bit request slices, port d at bits d*24 +: 24 |
| frame_err_cnt | output | 16 | Saturating count of sync-byte failures |
| parity_err_cnt | output | 16 | Saturating count of parity failures |

## Verification
Counter saturation is the hardest state to reach from the ports, because it needs 65535 rejected headers. The bench holds `hdr_valid` high with a bad sync byte for slightly more than that many cycles. It then checks that the framing counter rests at its ceiling and that the parity counter has not moved. The blocked-hand-off case also needs careful timing. A request is parked on a port that is not ready while the other ports are ready. A second header then waits at the input, and `slot_cnt` changes before the port is released. This shows that the timestamp is taken at acceptance, not at presentation.

// File: rtl/bhr_pkg.sv
`timescale 1ns/1ps
// bhr_pkg: header field positions, the request body record and the
// parity fold shared by the burst header receiver.
// Assumes the 34-bit header layout given in the brief.
package bhr_pkg;
    localparam int HDR_W      = 34;
    localparam int PAY_W      = 18;
    localparam int DEST_W     = 2;
    localparam int NUM_DEST   = 1 << DEST_W;
    localparam int BODY_W     = 16;
    localparam int PAY_LSB    = 16;
    localparam int DEST_LSB   = 31;
    localparam int PAR_LSB    = 8;
    localparam int SYNC_LSB   = 0;

    // Request fields without the timestamp; the timestamp is appended by the top.
    typedef struct packed {
        logic       qos;
        logic [1:0] grp;
        logic [3:0] chan;
        logic [3:0] len;
        logic [4:0] off;
    } req_body_t;

    // Fold the payload, zero-padded to three bytes, into one XOR byte.
    function automatic logic [7:0] fold_parity(input logic [PAY_W-1:0] pay);
        logic [23:0] wide;
        wide = {{(24-PAY_W){1'b0}}, pay};
        return wide[23:16] ^ wide[15:8] ^ wide[7:0];
    endfunction
endpackage

// File: rtl/hdr_check.sv
`timescale 1ns/1ps
// hdr_check: combinational decode of one header word. It reports whether
// the sync byte and the parity byte are correct, extracts the destination
// and rebuilds the request body without the destination.
// Assumes the header layout fixed in bhr_pkg.
module hdr_check
    import bhr_pkg::*;
#(
    parameter logic [7:0] SYNC_BYTE = 8'hA5
) (
    input  logic [HDR_W-1:0]  hdr,
    output logic              sync_ok,
    output logic              parity_ok,
    output logic [DEST_W-1:0] dest,
    output req_body_t         body
);
    logic [PAY_W-1:0] payload;
    logic [7:0]       par_field;
    logic [7:0]       sync_field;

    // Split the header into its payload, parity and sync fields.
    always_comb begin
        payload    = hdr[PAY_LSB +: PAY_W];
        par_field  = hdr[PAR_LSB +: 8];
        sync_field = hdr[SYNC_LSB +: 8];
    end

    // Evaluate both acceptance checks.
    always_comb begin
        sync_ok   = (sync_field == SYNC_BYTE);
        parity_ok = (par_field == fold_parity(payload));
    end

    // Drop the destination and pack the remaining fields in request order.
    always_comb begin
        dest      = hdr[DEST_LSB +: DEST_W];
        body.qos  = payload[17];
        body.grp  = payload[14:13];
        body.chan = payload[12:9];
        body.len  = payload[8:5];
        body.off  = payload[4:0];
    end
endmodule

// File: rtl/err_counter.sv
`timescale 1ns/1ps
// err_counter: a saturating event counter. It counts up by one for each
// cycle that inc is high and stops at its all-ones value.
// Assumes inc is a single-cycle qualified event.
module err_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // Count qualified events and hold once the ceiling is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    // R10: a counter at its ceiling stays there.
    p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R1, R2: the count moves only on a qualified event.
    p_idle_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));
endmodule

// File: rtl/req_router.sv
`timescale 1ns/1ps
// req_router: a one-entry holding register that steers its request to one
// of NUM_DEST ready/valid ports. It reports when it is free, meaning it is
// empty or its request leaves this cycle, so that a new request can load
// on the same edge.
// Assumes load is asserted only while free is high.
module req_router #(
    parameter int NUM_DEST = 4,
    parameter int DEST_W   = 2,
    parameter int REQ_W    = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [DEST_W-1:0]         load_dest,
    input  logic [REQ_W-1:0]          load_rec,
    output logic                      free,
    output logic [NUM_DEST-1:0]       req_valid,
    input  logic [NUM_DEST-1:0]       req_ready,
    output logic [NUM_DEST*REQ_W-1:0] req_data
);
    logic              hold_valid;
    logic [DEST_W-1:0] hold_dest;
    logic [REQ_W-1:0]  hold_rec;
    logic              leaving;

    // The held request leaves when its own port is ready.
    always_comb begin
        leaving = hold_valid && req_ready[hold_dest];
        free    = !hold_valid || leaving;
    end

    // Load a new request, or empty the register once the request has left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_dest  <= '0;
            hold_rec   <= '0;
        end else if (load) begin
            hold_valid <= 1'b1;
            hold_dest  <= load_dest;
            hold_rec   <= load_rec;
        end else if (leaving) begin
            hold_valid <= 1'b0;
        end
    end

    // Fan out the held request; only the selected port sees valid and data.
    for (genvar g = 0; g < NUM_DEST; g++) begin : g_port
        always_comb begin
            req_valid[g]                = hold_valid && (hold_dest == DEST_W'(g));
            req_data[g*REQ_W +: REQ_W]  = (hold_dest == DEST_W'(g)) ? hold_rec : '0;
        end
    end

    // R7: at most one port carries a request.
    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_valid));

    // R8: a request refused by its port stays in place, unchanged.
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_valid & ~req_ready)) |=> ($stable(req_valid) && $stable(req_data)));
endmodule

// File: rtl/burst_hdr_rx.sv
`timescale 1ns/1ps
// burst_hdr_rx: the top of the burst header receiver. It accepts one header
// per cycle, checks sync and parity, stamps valid headers with slot_cnt and
// routes them to a destination port. Rejected headers are counted in two
// saturating counters, and the framing counter takes precedence.
// Assumes slot_cnt is synchronous to clk.
module burst_hdr_rx
    import bhr_pkg::*;
#(
    parameter int         TS_W      = 8,
    parameter int         CNT_W     = 16,
    parameter logic [7:0] SYNC_BYTE = 8'hA5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                hdr_valid,
    output logic                                hdr_ready,
    input  logic [HDR_W-1:0]                    hdr_data,
    input  logic [TS_W-1:0]                     slot_cnt,
    output logic [NUM_DEST-1:0]                 req_valid,
    input  logic [NUM_DEST-1:0]                 req_ready,
    output logic [NUM_DEST*(BODY_W+TS_W)-1:0]   req_data,
    output logic [CNT_W-1:0]                    frame_err_cnt,
    output logic [CNT_W-1:0]                    parity_err_cnt
);
    localparam int REQ_W = BODY_W + TS_W;

    logic              sync_ok;
    logic              parity_ok;
    logic [DEST_W-1:0] dest;
    req_body_t         body;
    logic              free;
    logic              accept;
    logic              load;
    logic              inc_frame;
    logic              inc_parity;

    hdr_check #(.SYNC_BYTE(SYNC_BYTE)) u_check (
        .hdr       (hdr_data),
        .sync_ok   (sync_ok),
        .parity_ok (parity_ok),
        .dest      (dest),
        .body      (body)
    );

    // Accept a header when the holding stage is free; classify the outcome.
    always_comb begin
        hdr_ready  = free;
        accept     = hdr_valid && free;
        load       = accept && sync_ok && parity_ok;
        inc_frame  = accept && !sync_ok;
        inc_parity = accept && sync_ok && !parity_ok;
    end

    req_router #(.NUM_DEST(NUM_DEST), .DEST_W(DEST_W), .REQ_W(REQ_W)) u_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_dest (dest),
        .load_rec  ({body, slot_cnt}),
        .free      (free),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_data  (req_data)
    );

    err_counter #(.W(CNT_W)) u_frame_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_frame),
        .cnt   (frame_err_cnt)
    );

    err_counter #(.W(CNT_W)) u_parity_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_parity),
        .cnt   (parity_err_cnt)
    );

    // R1, R2: a rejected header leaves no request behind.
    p_bad_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && !(sync_ok && parity_ok)) |=> (req_valid == '0));

    // R4: a valid header appears on exactly the port its destination selects.
    p_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && sync_ok && parity_ok)
        |=> (req_valid == (NUM_DEST'(1) << $past(dest))));

    // R8: input ready stays low while a request is refused by its port.
    p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_valid & ~req_ready)) |-> !hdr_ready);
endmodule

// File: tb/burst_hdr_rx_tb.sv
`timescale 1ns/1ps
// burst_hdr_rx_tb: directed bench with one task per scenario.
module burst_hdr_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [33:0] hdr_data = '0;
    logic [7:0]  slot_cnt = '0;
    logic [3:0]  req_valid;
    logic [3:0]  req_ready = '0;
    logic [95:0] req_data;
    logic [15:0] frame_err_cnt;
    logic [15:0] parity_err_cnt;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    burst_hdr_rx u_dut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_data(hdr_data), .slot_cnt(slot_cnt), .req_valid(req_valid),
        .req_ready(req_ready), .req_data(req_data),
        .frame_err_cnt(frame_err_cnt), .parity_err_cnt(parity_err_cnt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Build a header; bad_sync and bad_par corrupt the respective bytes.
    function automatic logic [33:0] mk(input logic q, input logic [1:0] d, input logic [1:0] g,
                                       input logic [3:0] c, input logic [3:0] l, input logic [4:0] o,
                                       input logic bad_sync, input logic bad_par);
        logic [17:0] p;
        logic [7:0]  par;
        p   = {q, d, g, c, l, o};
        par = '0;
        for (int i = 0; i < 18; i++) par[i % 8] ^= p[i];
        if (bad_par) par ^= 8'h10;
        return {p, par, bad_sync ? 8'h5A : 8'hA5};
    endfunction

    function automatic logic [23:0] exp_req(input logic q, input logic [1:0] g, input logic [3:0] c,
                                            input logic [3:0] l, input logic [4:0] o, input logic [7:0] ts);
        return {q, g, c, l, o, ts};
    endfunction

    // Present one header for one edge, then sample at the next falling edge.
    task automatic send(input logic [33:0] h, input logic [7:0] ts);
        @(negedge clk);
        hdr_data = h; slot_cnt = ts; hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 req_valid", req_valid, 0);
        chk("R11 frame cnt", frame_err_cnt, 0);
        chk("R11 parity cnt", parity_err_cnt, 0);
        chk("R11 hdr_ready", hdr_ready, 1);
    endtask

    task automatic t_route_each;
        req_ready = 4'b0000;
        for (int d = 0; d < 4; d++) begin
            send(mk(d[0], d[1:0], 2'(d+1), 4'(3*d+1), 4'(9-d), 5'(7*d+2), 0, 0), 8'(40+d));
            chk("R4 one port", req_valid, 4'b1 << d);
            chk("R5 R6 record", req_data[d*24 +: 24],
                exp_req(d[0], 2'(d+1), 4'(3*d+1), 4'(9-d), 5'(7*d+2), 8'(40+d)));
            chk("R8 ready low", hdr_ready, 0);
            req_ready = 4'b1111;
            @(negedge clk);
            chk("R9 drained", req_valid, 0);
            req_ready = 4'b0000;
        end
    endtask

    task automatic t_sync_err;
        logic [15:0] f0, p0;
        f0 = frame_err_cnt; p0 = parity_err_cnt;
        send(mk(1, 2, 1, 5, 6, 7, 1, 0), 8'd3);
        chk("R1 no request", req_valid, 0);
        chk("R1 frame count", frame_err_cnt, f0 + 1);
        chk("R1 parity untouched", parity_err_cnt, p0);
    endtask

    task automatic t_parity_err;
        logic [15:0] f0, p0;
        f0 = frame_err_cnt; p0 = parity_err_cnt;
        send(mk(0, 3, 2, 9, 4, 17, 0, 1), 8'd4);
        chk("R2 no request", req_valid, 0);
        chk("R2 parity count", parity_err_cnt, p0 + 1);
        chk("R2 frame untouched", frame_err_cnt, f0);
    endtask

    task automatic t_both_err;
        logic [15:0] f0, p0;
        f0 = frame_err_cnt; p0 = parity_err_cnt;
        send(mk(1, 1, 3, 15, 15, 31, 1, 1), 8'd5);
        chk("R3 no request", req_valid, 0);
        chk("R3 frame count", frame_err_cnt, f0 + 1);
        chk("R3 parity untouched", parity_err_cnt, p0);
    endtask

    task automatic t_backpressure;
        req_ready = 4'b1011;
        send(mk(1, 2, 1, 4, 3, 9, 0, 0), 8'd10);
        chk("R8 held port", req_valid, 4'b0100);
        chk("R8 ready low", hdr_ready, 0);
        hdr_data = mk(0, 1, 2, 6, 8, 20, 0, 0); slot_cnt = 8'd20; hdr_valid = 1'b1;
        @(negedge clk);
        chk("R8 still held", req_valid, 4'b0100);
        chk("R8 data stable", req_data[2*24 +: 24], exp_req(1, 1, 4, 3, 9, 8'd10));
        chk("R8 others ignored", hdr_ready, 0);
        slot_cnt = 8'd21;
        req_ready = 4'b0100;
        @(negedge clk);
        hdr_valid = 1'b0;
        chk("R9 same-edge swap", req_valid, 4'b0010);
        chk("R6 ts at accept", req_data[1*24 +: 24], exp_req(0, 2, 6, 8, 20, 8'd21));
        req_ready = 4'b1111;
        @(negedge clk);
        chk("R9 emptied", req_valid, 0);
    endtask

    task automatic t_stream;
        req_ready = 4'b1111;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R9 stream port", req_valid, 4'b1 << ((i-1) % 4));
                chk("R9 stream data", req_data[((i-1)%4)*24 +: 24],
                    exp_req(0, 2'(i-1), 4'(i-1), 4'(i), 5'(i+10), 8'(100+i-1)));
            end
            if (i < 5) begin
                hdr_data = mk(0, 2'(i % 4), 2'(i), 4'(i), 4'(i+1), 5'(i+11), 0, 0);
                slot_cnt = 8'(100+i);
                hdr_valid = 1'b1;
            end else hdr_valid = 1'b0;
        end
    endtask

    task automatic t_saturate;
        logic [15:0] p0;
        p0 = parity_err_cnt;
        @(negedge clk);
        hdr_data = mk(0, 0, 0, 0, 0, 0, 1, 0); hdr_valid = 1'b1;
        repeat (65540) @(negedge clk);
        hdr_valid = 1'b0;
        @(negedge clk);
        chk("R10 frame ceiling", frame_err_cnt, 16'hFFFF);
        chk("R10 parity untouched", parity_err_cnt, p0);
        send(mk(0, 0, 0, 0, 0, 0, 1, 0), 8'd0);
        chk("R10 no wrap", frame_err_cnt, 16'hFFFF);
    endtask

    initial begin
        #(10 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_route_each;
        t_sync_err;
        t_parity_err;
        t_both_err;
        t_backpressure;
        t_stream;
        t_saturate;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule